// File: doc/BRIEF.md
# Addressable Board Test-Bus Bridge

This block joins one board to a shared backplane test bus (clock, mode select, serial in, serial out) and fans that bus out to several local scan chains. After reset it sits unselected and only listens for a board address. The address is shifted in through an instruction-register scan. A bridge whose slot pins match that address becomes selected and drives the backplane serial output. A fixed broadcast address selects every bridge at once, but none of them drives the output.

Once selected, the bridge decodes instructions shifted into its own instruction register. A per-port enable mask, held in a mode register, chooses which local ports an instruction acts on. Ports can be inserted into the scan path, where their mode-select line follows the backplane. They can also be parked in Run-Test/Idle, with the mode-select line held low so that a loaded local instruction stays in force. Further instructions release the selection or force every local TAP through Test-Logic-Reset. The serial chain runs from the bridge's own register through each inserted port in ascending order.

Top module: `jbr_top`

## Requirements
- R1: After `trst_n` is asserted the bridge is unselected. `tdo_oe` stays low during any scan, and every `lp_tms` bit is low whatever `tms` is.
- R2: At Update-IR, an unselected bridge whose shifted-in 8-bit value equals `slot_addr` becomes selected. Any other value except the broadcast value leaves it unselected.
- R3: The shifted-in value 0x3B selects an unselected bridge in broadcast form. In this form `tdo_oe` stays low during every scan.
- R4: Instruction 0x01 makes the data register the mode register, NPORT bits shifted LSB first with bit i enabling port i. The register is written at Update-DR.
- R5: Instruction 0x02 unparks every port whose mode bit is set. A port that is selected, enabled and unparked drives `lp_tms` equal to `tms` in the same cycle, with no register in between.
- R6: Instruction 0x03 parks every port whose mode bit is set. A parked port holds `lp_tms` low.
- R7: Instruction 0x04 deselects the bridge and forces all `lp_tms` low. Park states and the mode register are kept and are seen again after reselection.
- R8: Instruction 0x05 drives every `lp_tms` high for exactly RST_CYC clock cycles after its Update-IR edge, regardless of `tms`. Afterwards all ports are parked.
- R9: In Shift-IR or Shift-DR, a selected non-broadcast bridge raises `tdo_oe`. `tdo` then carries the bridge's own register LSB first, passed through the inserted ports in ascending order, and it changes on the falling clock edge. IR capture loads 0x01. Any instruction code without a function listed here, 0xFF included, selects a 1-bit bypass register that captures 0.
- R10: The own TAP reaches Test-Logic-Reset after five rising edges with `tms` high. That state clears the selection and keeps the mode and park states. `trst_n` low also clears the mode register and parks every port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Backplane mode select |
| tdi | input | 1 | Backplane serial data in |
| slot_addr | input | IR_W | Static board slot address |
| tdo | output | 1 | Backplane serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| lp_tms | output | NPORT | Mode select to each local chain |
| lp_tdi | output | NPORT | Serial data into each local chain |
| lp_tdo | input | NPORT | Serial data returned by each local chain |

## Verification
The bench uses the defaults: three local ports, an 8-bit register width and a five-cycle reset pulse. Three ports are enough to show a non-contiguous mask (ports 0 and 2) and a single middle port chosen alone. They also show ports that keep their park state while the mode mask changes around them. With a five-cycle reset window the bench can count the exact edge at which the forced-high pulse ends.

// File: rtl/jbr_pkg.sv
package jbr_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    localparam int OP_MODE   = 'h01;
    localparam int OP_UNPARK = 'h02;
    localparam int OP_PARK   = 'h03;
    localparam int OP_GOWAIT = 'h04;
    localparam int OP_SRESET = 'h05;
    localparam int OP_BYPASS = 'hFF;
    localparam int IR_CAPTURE = 'h01;

endpackage

// File: rtl/jbr_tap.sv
module jbr_tap
    import jbr_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   state_d = tms ? TS_EX1_DR   : TS_SHIFT_DR;
            TS_SHIFT_DR: state_d = tms ? TS_EX1_DR   : TS_SHIFT_DR;
            TS_EX1_DR:   state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: state_d = tms ? TS_EX2_DR   : TS_PAUSE_DR;
            TS_EX2_DR:   state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   state_d = tms ? TS_EX1_IR   : TS_SHIFT_IR;
            TS_SHIFT_IR: state_d = tms ? TS_EX1_IR   : TS_SHIFT_IR;
            TS_EX1_IR:   state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: state_d = tms ? TS_EX2_IR   : TS_PAUSE_IR;
            TS_EX2_IR:   state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            default:     state_d = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= TS_RESET;
        else         state_q <= state_d;
    end

    assign state = state_q;

    // Run of consecutive high-mode-select edges, saturating, for the check below.
    logic [2:0] ones_d, ones_q;
    always_comb begin
        ones_d = tms ? ((ones_q == 3'd7) ? ones_q : ones_q + 3'd1) : 3'd0;
    end
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) ones_q <= 3'd0;
        else         ones_q <= ones_d;
    end

    p_five_high_reset_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd5) |-> (state_q == TS_RESET));

endmodule

// File: rtl/jbr_lane.sv
module jbr_lane (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic selected,
    input  logic mode_bit,
    input  logic unpark_p,
    input  logic park_p,
    input  logic sreset_p,
    input  logic force_hi,
    output logic lp_tms,
    output logic in_chain
);

    logic parked_d, parked_q;

    always_comb begin
        parked_d = parked_q;
        if (sreset_p)                  parked_d = 1'b1;
        else if (park_p && mode_bit)   parked_d = 1'b1;
        else if (unpark_p && mode_bit) parked_d = 1'b0;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) parked_q <= 1'b1;
        else         parked_q <= parked_d;
    end

    assign in_chain = selected & mode_bit & ~parked_q;
    assign lp_tms   = force_hi | (in_chain & tms);

    p_parked_quiet_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (parked_q && !force_hi) |-> !lp_tms);

    p_sreset_parks_r8: assert property (@(posedge tck) disable iff (!trst_n)
        sreset_p |=> parked_q);

endmodule

// File: rtl/jbr_chain.sv
module jbr_chain #(
    parameter int NPORT = 3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             own_out,
    input  logic             shifting,
    input  logic             drive_en,
    input  logic [NPORT-1:0] in_chain,
    input  logic [NPORT-1:0] lp_tdo,
    output logic [NPORT-1:0] lp_tdi,
    output logic             tdo,
    output logic             tdo_oe
);

    logic chain_out;

    always_comb begin
        logic cur;
        cur = own_out;
        for (int i = 0; i < NPORT; i++) begin
            lp_tdi[i] = cur;
            if (in_chain[i]) cur = lp_tdo[i];
        end
        chain_out = cur;
    end

    logic tdo_d, tdo_q, oe_d, oe_q;

    always_comb begin
        tdo_d = shifting ? chain_out : tdo_q;
        oe_d  = shifting & drive_en;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            tdo_q <= tdo_d;
            oe_q  <= oe_d;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/jbr_top.sv
module jbr_top
    import jbr_pkg::*;
#(
    parameter int NPORT   = 3,
    parameter int IR_W    = 8,
    parameter int RST_CYC = 5,
    parameter logic [IR_W-1:0] BCAST = IR_W'('h3B)
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [IR_W-1:0]  slot_addr,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [NPORT-1:0] lp_tms,
    output logic [NPORT-1:0] lp_tdi,
    input  logic [NPORT-1:0] lp_tdo
);

    localparam int CNT_W = $clog2(RST_CYC + 1);
    localparam logic [IR_W-1:0] I_MODE   = IR_W'(OP_MODE);
    localparam logic [IR_W-1:0] I_UNPARK = IR_W'(OP_UNPARK);
    localparam logic [IR_W-1:0] I_PARK   = IR_W'(OP_PARK);
    localparam logic [IR_W-1:0] I_GOWAIT = IR_W'(OP_GOWAIT);
    localparam logic [IR_W-1:0] I_SRESET = IR_W'(OP_SRESET);
    localparam logic [IR_W-1:0] I_BYPASS = IR_W'(OP_BYPASS);

    typedef struct packed {
        logic [IR_W-1:0]  ir_sr;
        logic [IR_W-1:0]  ir;
        logic [NPORT-1:0] mode_sr;
        logic [NPORT-1:0] mode;
        logic             byp;
        logic             sel;
        logic             bcast;
        logic [CNT_W-1:0] rcnt;
    } ctrl_t;

    tap_state_e state;
    ctrl_t      st_d, st_q;

    jbr_tap u_tap (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    // Instruction pulses, taken at the Update-IR edge of a selected bridge.
    logic upd_sel, unpark_p, park_p, gowait_p, sreset_p;
    assign upd_sel  = (state == TS_UPD_IR) && st_q.sel;
    assign unpark_p = upd_sel && (st_q.ir_sr == I_UNPARK);
    assign park_p   = upd_sel && (st_q.ir_sr == I_PARK);
    assign gowait_p = upd_sel && (st_q.ir_sr == I_GOWAIT);
    assign sreset_p = upd_sel && (st_q.ir_sr == I_SRESET);

    logic [NPORT:0] mode_shift;
    assign mode_shift = {tdi, st_q.mode_sr};

    always_comb begin
        st_d = st_q;
        if (st_q.rcnt != '0) st_d.rcnt = st_q.rcnt - 1'b1;
        unique case (state)
            TS_RESET: begin
                st_d.sel   = 1'b0;
                st_d.bcast = 1'b0;
                st_d.ir    = I_BYPASS;
            end
            TS_CAP_IR:   st_d.ir_sr = IR_W'(IR_CAPTURE);
            TS_SHIFT_IR: st_d.ir_sr = {tdi, st_q.ir_sr[IR_W-1:1]};
            TS_UPD_IR: begin
                if (!st_q.sel) begin
                    if (st_q.ir_sr == slot_addr) begin
                        st_d.sel   = 1'b1;
                        st_d.bcast = 1'b0;
                    end else if (st_q.ir_sr == BCAST) begin
                        st_d.sel   = 1'b1;
                        st_d.bcast = 1'b1;
                    end
                end else begin
                    st_d.ir = st_q.ir_sr;
                    if (gowait_p) begin
                        st_d.sel   = 1'b0;
                        st_d.bcast = 1'b0;
                        st_d.ir    = I_BYPASS;
                    end
                    if (sreset_p) st_d.rcnt = CNT_W'(RST_CYC);
                end
            end
            TS_CAP_DR: begin
                st_d.mode_sr = st_q.mode;
                st_d.byp     = 1'b0;
            end
            TS_SHIFT_DR: begin
                if (st_q.sel && st_q.ir == I_MODE) st_d.mode_sr = mode_shift[NPORT:1];
                st_d.byp = tdi;
            end
            TS_UPD_DR: begin
                if (st_q.sel && st_q.ir == I_MODE) st_d.mode = st_q.mode_sr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q.ir_sr   <= '0;
            st_q.ir      <= I_BYPASS;
            st_q.mode_sr <= '0;
            st_q.mode    <= '0;
            st_q.byp     <= 1'b0;
            st_q.sel     <= 1'b0;
            st_q.bcast   <= 1'b0;
            st_q.rcnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic force_hi;
    logic [NPORT-1:0] in_chain;
    assign force_hi = (st_q.rcnt != '0);

    for (genvar g = 0; g < NPORT; g++) begin : g_lane
        jbr_lane u_lane (
            .tck      (tck),
            .trst_n   (trst_n),
            .tms      (tms),
            .selected (st_q.sel),
            .mode_bit (st_q.mode[g]),
            .unpark_p (unpark_p),
            .park_p   (park_p),
            .sreset_p (sreset_p),
            .force_hi (force_hi),
            .lp_tms   (lp_tms[g]),
            .in_chain (in_chain[g])
        );
    end

    logic shifting, own_out;
    assign shifting = (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
    always_comb begin
        if (state == TS_SHIFT_IR)                   own_out = st_q.ir_sr[0];
        else if (st_q.sel && st_q.ir == I_MODE)     own_out = st_q.mode_sr[0];
        else                                        own_out = st_q.byp;
    end

    jbr_chain #(.NPORT(NPORT)) u_chain (
        .tck      (tck),
        .trst_n   (trst_n),
        .own_out  (own_out),
        .shifting (shifting),
        .drive_en (st_q.sel & ~st_q.bcast),
        .in_chain (in_chain),
        .lp_tdo   (lp_tdo),
        .lp_tdi   (lp_tdi),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    p_wait_silent_r1: assert property (@(posedge tck) disable iff (!trst_n)
        !st_q.sel |-> !tdo_oe);

    p_bcast_silent_r3: assert property (@(posedge tck) disable iff (!trst_n)
        st_q.bcast |-> !tdo_oe);

    p_follow_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (!force_hi && tms) |-> ((lp_tms & in_chain) == in_chain));

    p_deselect_quiet_r7: assert property (@(posedge tck) disable iff (!trst_n)
        gowait_p |=> (in_chain == '0));

    p_force_all_r8: assert property (@(posedge tck) disable iff (!trst_n)
        force_hi |-> (&lp_tms));

    p_rcnt_step_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (force_hi && !sreset_p) |=> (st_q.rcnt == $past(st_q.rcnt) - 1'b1));

    p_tlr_clears_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET) |=> !st_q.sel);

endmodule

// File: tb/jbr_top_tb_top.sv
module jbr_top_tb_top;

    localparam int NPORT = 3;
    localparam logic [7:0] SLOT = 8'h12;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b0;
    logic tdi = 1'b0;
    logic [NPORT-1:0] lp_tdo = '0;
    logic tdo, tdo_oe;
    logic [NPORT-1:0] lp_tms, lp_tdi;

    always #10 tck = ~tck;

    jbr_top dut_i (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .tdi       (tdi),
        .slot_addr (SLOT),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .lp_tms    (lp_tms),
        .lp_tdi    (lp_tdi),
        .lp_tdo    (lp_tdo)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic d);
        @(negedge tck);
        #1;
        tms = t;
        tdi = d;
    endtask

    // Shifts n bits (IR or DR) from Run-Test/Idle and returns to it.
    task automatic scan(input bit ir, input logic [7:0] data, input int n,
                        output logic [7:0] cap, output bit oe_all, output bit oe_any);
        cap = '0;
        oe_all = 1'b1;
        oe_any = 1'b0;
        step(1'b1, 1'b0);
        if (ir) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, data[i]);
            #4;
            cap[i] = tdo;
            oe_all = oe_all & tdo_oe;
            oe_any = oe_any | tdo_oe;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic probe(output logic [NPORT-1:0] act);
        @(negedge tck);
        #1;
        tms = 1'b1;
        #2;
        act = lp_tms;
        tms = 1'b0;
    endtask

    // {ir, data, length, expected active mask, requirement}
    localparam int NROW = 15;
    localparam logic [19:0] TBL [NROW] = '{
        {1'b1, 8'h12, 4'd8, 3'b000, 4'd2},  // R2 own address
        {1'b1, 8'h01, 4'd8, 3'b000, 4'd4},  // R4 mode instruction
        {1'b0, 8'h02, 4'd3, 3'b000, 4'd4},  // R4 mode = port 1
        {1'b1, 8'h02, 4'd8, 3'b010, 4'd5},  // R5 unpark
        {1'b1, 8'h01, 4'd8, 3'b010, 4'd4},
        {1'b0, 8'h05, 4'd3, 3'b000, 4'd4},  // R4 mode = ports 0,2
        {1'b1, 8'h02, 4'd8, 3'b101, 4'd5},  // R5 unpark 0,2
        {1'b1, 8'h03, 4'd8, 3'b000, 4'd6},  // R6 park 0,2
        {1'b1, 8'h01, 4'd8, 3'b000, 4'd4},
        {1'b0, 8'h07, 4'd3, 3'b010, 4'd4},  // R4 mode = all
        {1'b1, 8'h04, 4'd8, 3'b000, 4'd7},  // R7 release
        {1'b1, 8'h3B, 4'd8, 3'b010, 4'd3},  // R3 broadcast, state kept (R7)
        {1'b1, 8'h04, 4'd8, 3'b000, 4'd7},
        {1'b1, 8'h55, 4'd8, 3'b000, 4'd2},  // R2 foreign address
        {1'b1, 8'h12, 4'd8, 3'b010, 4'd2}
    };

    initial begin
        logic [7:0] cap;
        bit oe_all, oe_any;
        logic [NPORT-1:0] act;

        #35;
        trst_n = 1'b1;

        // R1 reset state
        probe(act);
        check("R1", act, 3'b000, "lp_tms after reset");
        check("R1", tdo_oe, 1'b0, "tdo_oe after reset");

        for (int r = 0; r < NROW; r++) begin
            scan(TBL[r][19], TBL[r][18:11], int'(TBL[r][10:7]), cap, oe_all, oe_any);
            if (r == 0) check("R1", oe_any, 1'b0, "tdo_oe while unselected");
            probe(act);
            check($sformatf("R%0d", TBL[r][3:0]), act, TBL[r][6:4], $sformatf("row %0d active ports", r));
        end

        // R9 chain through port 1
        lp_tdo = 3'b010;
        scan(1'b0, 8'h00, 4, cap, oe_all, oe_any);
        check("R9", cap[3:0], 4'b1111, "tdo via port1 high");
        check("R9", oe_all, 1'b1, "tdo_oe during shift");
        lp_tdo = 3'b101;
        scan(1'b0, 8'h00, 4, cap, oe_all, oe_any);
        check("R9", cap[3:0], 4'b0000, "tdo via port1 low");

        // R3 broadcast never drives
        scan(1'b1, 8'h04, 8, cap, oe_all, oe_any);
        scan(1'b1, 8'h3B, 8, cap, oe_all, oe_any);
        scan(1'b0, 8'h00, 4, cap, oe_all, oe_any);
        check("R3", oe_any, 1'b0, "tdo_oe in broadcast");

        // R10 five high mode-select edges
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        probe(act);
        check("R10", act, 3'b000, "ports after TAP reset");
        scan(1'b0, 8'h00, 4, cap, oe_all, oe_any);
        check("R10", oe_any, 1'b0, "tdo_oe after TAP reset");
        scan(1'b1, SLOT, 8, cap, oe_all, oe_any);
        probe(act);
        check("R10", act, 3'b010, "mode and park kept over TAP reset");

        // R8 soft reset pulse
        scan(1'b1, 8'h05, 8, cap, oe_all, oe_any);
        for (int k = 0; k < 6; k++) begin
            @(negedge tck);
            #3;
            check("R8", lp_tms, (k < 5) ? 3'b111 : 3'b000, $sformatf("forced cycle %0d", k));
        end
        probe(act);
        check("R8", act, 3'b000, "ports parked after soft reset");

        // R9 IR capture and bypass with no port inserted
        scan(1'b1, 8'hFF, 8, cap, oe_all, oe_any);
        check("R9", cap, 8'h01, "IR capture value");
        check("R9", oe_all, 1'b1, "tdo_oe in Shift-IR");
        scan(1'b0, 8'h03, 2, cap, oe_all, oe_any);
        check("R9", cap[1:0], 2'b10, "bypass capture then data");

        // R10 hard reset clears mode too
        @(negedge tck);
        trst_n = 1'b0;
        #5;
        trst_n = 1'b1;
        scan(1'b1, SLOT, 8, cap, oe_all, oe_any);
        scan(1'b1, 8'h02, 8, cap, oe_all, oe_any);
        probe(act);
        check("R10", act, 3'b000, "mode cleared by trst_n");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule